// File: doc/BRIEF.md
# Effect Handler Lookup CAM

This block keeps the effect handlers that are currently installed and turns a perform request into the code address of the handler that must run. Each resident entry holds a key made of a 4-bit effect family and a 4-bit operation. It also holds the absolute handler address and an install ordinal that grows with every install. The core installs a handler by giving the key, the program counter of the install and a signed offset to the handler body. It removes handlers in stack order with a pop. It asks for a handler with a lookup.

A lookup compares the key against all eight entries in parallel. When several entries carry the same key, the entry that was installed last wins. Which slot holds an entry has no effect on the result. When no entry matches, the block reports a miss, and the core must then walk the spilled handlers in memory, which is slow. When all eight slots are in use, a further install pushes the oldest entry out on a spill port, so the eight newest handlers always stay resident.

Top module: `handler_cam`

## Requirements
- R1: After reset the store is empty: count is 0, full is low, and look_hit, look_miss, spill_valid and pop_err are all low.
- R2: A lookup whose key matches a resident entry raises look_hit on the clock edge after the request. look_addr then equals the install pc plus the install offset, with the offset read as a sign-extended two's-complement value and the sum taken modulo 2^16.
- R3: A lookup that matches no resident entry raises look_miss, and not look_hit, on the clock edge after the request. In a cycle after which no lookup was requested, both look_hit and look_miss are low.
- R4: When several resident entries carry the same key, the lookup returns the one installed most recently. This holds whatever slots the entries occupy.
- R5: The key is the full 4-bit family and 4-bit op. Entries that differ in either field do not match. Family 0 and family 15 are matched like any other family.
- R6: count gives the number of resident entries and goes up by one for each install into a store that is not full. full is high exactly when 8 entries are resident.
- R7: An install into a full store evicts the entry with the oldest install. On the next cycle spill_valid pulses for one cycle and carries that entry's family, op and address. count stays at 8, and the evicted key then misses.
- R8: A pop removes the most recently installed resident entry. An older entry with the same key that it was shadowing becomes the lookup result again.
- R9: A pop on an empty store raises pop_err for one cycle and leaves the store unchanged.
- R10: When an install and a pop are requested in the same cycle, the install takes place and the pop is ignored.
- R11: A lookup made in the same cycle as an install or a pop sees the store contents from before that update.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| inst_valid | input | 1 | Install request |
| inst_family | input | 4 | Family of the handler to install |
| inst_op | input | 4 | Operation of the handler to install |
| inst_pc | input | 16 | Program counter of the install |
| inst_offset | input | 8 | Signed offset from inst_pc to the handler body |
| pop_valid | input | 1 | Remove the most recently installed resident entry |
| look_valid | input | 1 | Lookup request |
| look_family | input | 4 | Family being performed |
| look_op | input | 4 | Operation being performed |
| look_hit | output | 1 | Registered: the lookup found a handler |
| look_miss | output | 1 | Registered: the lookup missed, so memory must be searched |
| look_addr | output | 16 | Registered handler address on a hit |
| spill_valid | output | 1 | One-cycle pulse: an entry was evicted to memory |
| spill_family | output | 4 | Family of the evicted entry |
| spill_op | output | 4 | Operation of the evicted entry |
| spill_addr | output | 16 | Handler address of the evicted entry |
| pop_err | output | 1 | One-cycle pulse: a pop was made on an empty store |
| count | output | 4 | Number of resident entries |
| full | output | 1 | All slots are resident |

## Verification
The assertions check, on every cycle, the rules that link a request to the response on the next edge. These are: exactly one of hit or miss after each lookup and neither without one, the change in count after an install or a pop, a spill pulse after each install into a full store, and the error pulse after a pop on an empty store. Which entry wins a match, the address it returns, which entry gets evicted, and the return of a shadowed handler after a pop all depend on the history of installs. Only the directed bench scenarios can show those.

// File: rtl/handler_cam.sv
module handler_cam #(
  parameter int ENTRIES = 8,
  parameter int FAM_W   = 4,
  parameter int OP_W    = 4,
  parameter int ADDR_W  = 16,
  parameter int OFS_W   = 8,
  parameter int ID_W    = 16
) (
  input  logic                               clk,
  input  logic                               rst_n,
  input  logic                               inst_valid,
  input  logic [FAM_W-1:0]                   inst_family,
  input  logic [OP_W-1:0]                    inst_op,
  input  logic [ADDR_W-1:0]                  inst_pc,
  input  logic [OFS_W-1:0]                   inst_offset,
  input  logic                               pop_valid,
  input  logic                               look_valid,
  input  logic [FAM_W-1:0]                   look_family,
  input  logic [OP_W-1:0]                    look_op,
  output logic                               look_hit,
  output logic                               look_miss,
  output logic [ADDR_W-1:0]                  look_addr,
  output logic                               spill_valid,
  output logic [FAM_W-1:0]                   spill_family,
  output logic [OP_W-1:0]                    spill_op,
  output logic [ADDR_W-1:0]                  spill_addr,
  output logic                               pop_err,
  output logic [$clog2(ENTRIES+1)-1:0]       count,
  output logic                               full
);
  localparam int IDX_W = $clog2(ENTRIES);
  localparam int CNT_W = $clog2(ENTRIES+1);
  localparam int KEY_W = FAM_W + OP_W;

  logic [ENTRIES-1:0] vld;
  logic [KEY_W-1:0]   key_q  [ENTRIES];
  logic [ADDR_W-1:0]  addr_q [ENTRIES];
  logic [ID_W-1:0]    id_q   [ENTRIES];
  logic [ID_W-1:0]    next_id;

  logic [KEY_W-1:0]   look_key, inst_key;
  logic [ADDR_W-1:0]  inst_addr;
  assign look_key  = {look_family, look_op};
  assign inst_key  = {inst_family, inst_op};
  assign inst_addr = inst_pc + {{(ADDR_W-OFS_W){inst_offset[OFS_W-1]}}, inst_offset};

  logic             free_found, any_vld, m_found;
  logic [IDX_W-1:0] free_idx, old_idx, new_idx, m_idx;
  logic [ID_W-1:0]  old_id, new_id, m_id;
  logic [CNT_W-1:0] cnt_c;

  always_comb begin
    free_found = 1'b0; free_idx = '0;
    any_vld = 1'b0; old_idx = '0; new_idx = '0; old_id = '0; new_id = '0;
    m_found = 1'b0; m_idx = '0; m_id = '0;
    cnt_c = '0;
    for (int i = ENTRIES-1; i >= 0; i--) begin
      if (!vld[i]) begin
        free_found = 1'b1;
        free_idx   = IDX_W'(i);
      end
    end
    for (int i = 0; i < ENTRIES; i++) begin
      if (vld[i]) begin
        cnt_c = cnt_c + CNT_W'(1);
        if (!any_vld || id_q[i] < old_id) begin
          old_id  = id_q[i];
          old_idx = IDX_W'(i);
        end
        if (!any_vld || id_q[i] > new_id) begin
          new_id  = id_q[i];
          new_idx = IDX_W'(i);
        end
        any_vld = 1'b1;
        if (key_q[i] == look_key && (!m_found || id_q[i] > m_id)) begin
          m_found = 1'b1;
          m_id    = id_q[i];
          m_idx   = IDX_W'(i);
        end
      end
    end
  end

  assign count = cnt_c;
  assign full  = (cnt_c == CNT_W'(ENTRIES));

  logic do_pop, pop_bad, evict;
  logic [IDX_W-1:0] ins_idx;
  assign do_pop  = pop_valid && !inst_valid && any_vld;
  assign pop_bad = pop_valid && !inst_valid && !any_vld;
  assign evict   = inst_valid && !free_found;
  assign ins_idx = free_found ? free_idx : old_idx;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vld          <= '0;
      next_id      <= '0;
      look_hit     <= 1'b0;
      look_miss    <= 1'b0;
      look_addr    <= '0;
      spill_valid  <= 1'b0;
      spill_family <= '0;
      spill_op     <= '0;
      spill_addr   <= '0;
      pop_err      <= 1'b0;
      for (int i = 0; i < ENTRIES; i++) begin
        key_q[i]  <= '0;
        addr_q[i] <= '0;
        id_q[i]   <= '0;
      end
    end else begin
      look_hit    <= look_valid && m_found;
      look_miss   <= look_valid && !m_found;
      look_addr   <= m_found ? addr_q[m_idx] : '0;
      spill_valid <= evict;
      pop_err     <= pop_bad;
      if (evict) begin
        spill_family <= key_q[old_idx][KEY_W-1:OP_W];
        spill_op     <= key_q[old_idx][OP_W-1:0];
        spill_addr   <= addr_q[old_idx];
      end
      if (inst_valid) begin
        vld[ins_idx]    <= 1'b1;
        key_q[ins_idx]  <= inst_key;
        addr_q[ins_idx] <= inst_addr;
        id_q[ins_idx]   <= next_id;
        next_id         <= next_id + ID_W'(1);
      end else if (do_pop) begin
        vld[new_idx] <= 1'b0;
        next_id      <= new_id;
      end
    end
  end

  assert_one_result_R3: assert property (@(posedge clk) disable iff (!rst_n)
    look_valid |=> (look_hit != look_miss));
  assert_quiet_result_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !look_valid |=> (!look_hit && !look_miss));
  assert_count_bound_R6: assert property (@(posedge clk) disable iff (!rst_n)
    count <= CNT_W'(ENTRIES));
  assert_install_grows_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (inst_valid && !full) |=> (count == $past(count) + CNT_W'(1)) && !spill_valid);
  assert_full_spills_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (inst_valid && full) |=> (spill_valid && full));
  assert_pop_shrinks_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (pop_valid && !inst_valid && count != '0) |=> (count == $past(count) - CNT_W'(1)) && !pop_err);
  assert_pop_empty_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (pop_valid && !inst_valid && count == '0) |=> (pop_err && count == '0));
endmodule

// File: tb/handler_cam_tb_top.sv
module handler_cam_tb_top;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        inst_valid, pop_valid, look_valid;
  logic [3:0]  inst_family, inst_op, look_family, look_op;
  logic [15:0] inst_pc;
  logic [7:0]  inst_offset;
  logic        look_hit, look_miss, spill_valid, pop_err, full;
  logic [15:0] look_addr, spill_addr;
  logic [3:0]  spill_family, spill_op, count;

  int n_chk = 0;
  int n_bad = 0;

  always #4 clk = ~clk;

  handler_cam dut_i (
    .clk(clk), .rst_n(rst_n),
    .inst_valid(inst_valid), .inst_family(inst_family), .inst_op(inst_op),
    .inst_pc(inst_pc), .inst_offset(inst_offset),
    .pop_valid(pop_valid),
    .look_valid(look_valid), .look_family(look_family), .look_op(look_op),
    .look_hit(look_hit), .look_miss(look_miss), .look_addr(look_addr),
    .spill_valid(spill_valid), .spill_family(spill_family), .spill_op(spill_op),
    .spill_addr(spill_addr), .pop_err(pop_err), .count(count), .full(full)
  );

  task automatic chk(string req, string what, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic int haddr(int pc, int ofs);
    return (pc + ofs) & 16'hFFFF;
  endfunction

  task automatic idle_inputs();
    inst_valid = 0; pop_valid = 0; look_valid = 0;
    inst_family = 0; inst_op = 0; inst_pc = 0; inst_offset = 0;
    look_family = 0; look_op = 0;
  endtask

  task automatic do_reset();
    idle_inputs();
    rst_n = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
  endtask

  task automatic drive_inst(int f, int o, int pc, int ofs);
    inst_valid = 1; inst_family = 4'(f); inst_op = 4'(o);
    inst_pc = 16'(pc); inst_offset = 8'(ofs);
  endtask

  task automatic drive_look(int f, int o);
    look_valid = 1; look_family = 4'(f); look_op = 4'(o);
  endtask

  task automatic step();
    @(negedge clk);
    idle_inputs();
  endtask

  task automatic install(int f, int o, int pc, int ofs);
    drive_inst(f, o, pc, ofs);
    step();
  endtask

  task automatic pop();
    pop_valid = 1;
    step();
  endtask

  task automatic expect_hit(string req, int f, int o, int addr);
    drive_look(f, o);
    step();
    chk(req, "look_hit", look_hit, 1);
    chk(req, "look_miss", look_miss, 0);
    chk(req, "look_addr", look_addr, addr);
  endtask

  task automatic expect_miss(string req, int f, int o);
    drive_look(f, o);
    step();
    chk(req, "look_hit", look_hit, 0);
    chk(req, "look_miss", look_miss, 1);
  endtask

  task automatic t_reset();
    do_reset();
    chk("R1", "count", count, 0);
    chk("R1", "full", full, 0);
    chk("R1", "look_hit", look_hit, 0);
    chk("R1", "look_miss", look_miss, 0);
    chk("R1", "spill_valid", spill_valid, 0);
    chk("R1", "pop_err", pop_err, 0);
    expect_miss("R3", 1, 2);
  endtask

  task automatic t_basic();
    do_reset();
    install(1, 2, 'h100, 'h10);
    install(15, 0, 'h200, -4);
    install(0, 9, 'hFFF0, 'h20);
    chk("R6", "count", count, 3);
    expect_hit("R2", 1, 2, 'h110);
    expect_hit("R2", 15, 0, 'h1FC);
    expect_hit("R5", 0, 9, haddr('hFFF0, 'h20));
    expect_miss("R5", 1, 3);
    expect_miss("R5", 2, 2);
    expect_miss("R5", 0, 0);
    chk("R3", "quiet look_hit", look_hit, 0);
    step();
    chk("R3", "quiet look_miss", look_miss, 0);
  endtask

  task automatic t_shadow();
    do_reset();
    install(3, 3, 'h400, 1);
    install(6, 1, 'h500, 2);
    install(3, 3, 'h600, 3);
    expect_hit("R4", 3, 3, 'h603);
    pop();
    chk("R8", "count after pop", count, 2);
    expect_hit("R8", 3, 3, 'h401);
    pop();
    expect_miss("R8", 6, 1);
    expect_hit("R8", 3, 3, 'h401);
  endtask

  task automatic t_pop_empty();
    do_reset();
    install(2, 2, 'h10, 0);
    pop();
    chk("R9", "pop_err normal", pop_err, 0);
    pop();
    chk("R9", "pop_err", pop_err, 1);
    chk("R9", "count", count, 0);
    step();
    chk("R9", "pop_err one cycle", pop_err, 0);
    expect_miss("R9", 2, 2);
  endtask

  task automatic t_capacity();
    do_reset();
    for (int i = 0; i < 8; i++) begin
      install(4, i, 'h1000 + 'h100 * i, i);
      chk("R6", "full early", full, (i == 7) ? 1 : 0);
    end
    chk("R6", "count full", count, 8);
    install(5, 0, 'h2000, 0);
    chk("R7", "spill_valid", spill_valid, 1);
    chk("R7", "spill_family", spill_family, 4);
    chk("R7", "spill_op", spill_op, 0);
    chk("R7", "spill_addr", spill_addr, 'h1000);
    chk("R7", "count", count, 8);
    step();
    chk("R7", "spill pulse", spill_valid, 0);
    expect_miss("R7", 4, 0);
    expect_hit("R7", 4, 1, 'h1101);
    expect_hit("R7", 5, 0, 'h2000);
    install(4, 7, 'h3000, 5);
    chk("R7", "second spill op", spill_op, 1);
    expect_hit("R4", 4, 7, 'h3005);
    pop();
    expect_hit("R4", 4, 7, 'h1707);
  endtask

  task automatic t_same_cycle();
    do_reset();
    install(7, 7, 'h700, 0);
    drive_inst(8, 8, 'h800, 0);
    pop_valid = 1;
    step();
    chk("R10", "count", count, 2);
    expect_hit("R10", 7, 7, 'h700);
    expect_hit("R10", 8, 8, 'h800);
    drive_inst(9, 1, 'h900, 0);
    drive_look(9, 1);
    step();
    chk("R11", "look during install", look_miss, 1);
    expect_hit("R11", 9, 1, 'h900);
    pop_valid = 1;
    drive_look(9, 1);
    step();
    chk("R11", "look during pop hit", look_hit, 1);
    chk("R11", "look during pop addr", look_addr, 'h900);
    expect_miss("R11", 9, 1);
  endtask

  initial begin
    #(8 * 100000);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    idle_inputs();
    rst_n = 0;
    t_reset();
    t_basic();
    t_shadow();
    t_pop_empty();
    t_capacity();
    t_same_cycle();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule